// File: doc/BRIEF.md
# Hardwired Instruction Cycle Controller

This block is the control unit and register datapath of a small CPU with one working register. A state machine steps each instruction through a fetch cycle, an optional indirect cycle, an execute cycle and an optional interrupt cycle. Each cycle is cut into fixed timing slots, and every slot issues one group of register transfers in one clock. The registers are a program counter, a memory address register, a memory buffer register, an instruction register and the accumulator R1. They live inside the block, and their values are brought out so the surrounding logic can observe architectural state.

Memory sits outside, behind a word-addressed port. The address is always the memory address register. Read data must be valid in the clock that follows the load of that register. A write is committed on the clock edge where the write strobe is high. Three instructions are executed: add memory to R1, increment memory and skip if the result is zero, and branch with the return address saved at the target. An instruction word can ask for one level of indirection. An interrupt request is taken between instructions when interrupts are enabled.

Top module: `instr_cycle_ctrl`

## Requirements
- R1: Fetch takes three clocks. The first loads the address register from the program counter. The second captures memory into the buffer and advances the program counter by one. The third copies the buffer into the instruction register.
- R2: When bit 11 of the fetched word is set, a three-clock indirect cycle follows fetch. It reads the word at the address field and replaces the instruction register's low 11 bits with that word's low 11 bits. Opcode and indirect bit are kept.
- R3: Opcode 1 (add) takes three execute clocks and leaves R1 = R1 + mem[X] modulo 2^16. R1 changes only in the last of those clocks.
- R4: Opcode 2 (increment-and-skip) takes four execute clocks. It writes mem[X]+1 back to X. When the written value is zero, the program counter advances by one more in the same clock as the write.
- R5: Opcode 3 (branch-and-save) takes three execute clocks. It stores the address of the following instruction, zero-extended, at X. It then resumes at X+1.
- R6: If the request input is high and interrupts are enabled in the last execute clock, a three-clock interrupt cycle follows. It stores the program counter at address 0 and continues at address 1.
- R7: Entering the interrupt cycle disables interrupts. While they are disabled, requests are ignored. A one-clock enable pulse re-enables them.
- R8: Any opcode other than 1, 2 or 3 uses a single execute clock. It leaves R1 and memory unchanged.
- R9: A synchronous active-low reset sets the program counter and R1 to 0 and interrupts to enabled. It starts at fetch slot 0 with no memory write.
- R10: An instruction word holds the opcode in bits 15:12, the indirect flag in bit 11 and the address in bits 10:0. The instruction register holds steady throughout execute.
- R11: Memory is written only in the fourth increment-and-skip clock, the second branch-and-save clock and the third interrupt clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 1 | Interrupt request level |
| irq_enable | input | 1 | One-clock pulse that re-enables interrupts |
| mem_addr | output | 11 | Memory word address (address register) |
| mem_rdata | input | 16 | Memory read data, valid the clock after the address loads |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data (buffer register) |
| pc_o | output | 11 | Program counter |
| r1_o | output | 16 | Accumulator R1 |
| ir_o | output | 16 | Instruction register |
| phase_o | output | 2 | Current cycle: 0 fetch, 1 indirect, 2 execute, 3 interrupt |
| slot_o | output | 2 | Timing slot within the current cycle |
| irq_on_o | output | 1 | Interrupts enabled |

## Verification
All architectural results of an instruction are due when the controller next returns to fetch slot 0. That takes 3 fetch clocks, plus 3 if indirect, plus 3, 4, 3 or 1 execute clocks by opcode, plus 3 if an interrupt is taken. The bench waits for that boundary on the falling edge. It counts the clocks spent and compares them with the sum predicted from the instruction. It then compares the program counter, R1, the instruction register, the interrupt enable and every word the instruction should have written. Slot-level timing, such as when the program counter moves, when R1 changes and where writes may occur, is checked clock by clock in the bound checker.

// File: rtl/icc_pkg.sv
// Package: shared field widths, cycle encoding, opcodes and the micro-operation
// control word used between the decoder and the datapath.
package icc_pkg;

    localparam int OPC_W  = 4;
    localparam int SLOT_W = 2;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_INDIR = 2'd1,
        PH_EXEC  = 2'd2,
        PH_INTR  = 2'd3
    } phase_e;

    localparam logic [OPC_W-1:0] OP_ADD = 4'd1;
    localparam logic [OPC_W-1:0] OP_ISZ = 4'd2;
    localparam logic [OPC_W-1:0] OP_BSA = 4'd3;

    // One group of register transfers issued in one slot.
    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ir;
        logic mar_from_save;
        logic mbr_from_mem;
        logic mbr_from_pc;
        logic mbr_plus1;
        logic ir_load;
        logic ir_addr_load;
        logic pc_plus1;
        logic pc_from_ir;
        logic pc_from_vec;
        logic r1_add;
        logic mem_write;
        logic last_slot;
    } uop_t;

endpackage

// File: rtl/icc_sequencer.sv
// Sequencer: holds the current cycle and timing slot and the interrupt enable.
// Assumes the decoder marks the final slot of each cycle with last_slot.
// Interrupt requests are sampled only in the final execute slot.
module icc_sequencer
    import icc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              last_slot,
    input  logic              ind_bit,
    input  logic              irq_req,
    input  logic              irq_enable,
    output phase_e            phase,
    output logic [SLOT_W-1:0] slot,
    output logic              irq_on
);

    logic take_irq;

    // Interrupt is taken at the end of execute when requested and enabled.
    always_comb take_irq = (phase == PH_EXEC) && last_slot && irq_req && irq_on;

    // Advance the slot, or move to the next cycle after a final slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_FETCH;
            slot  <= '0;
        end else if (last_slot) begin
            slot <= '0;
            unique case (phase)
                PH_FETCH: phase <= ind_bit ? PH_INDIR : PH_EXEC;
                PH_INDIR: phase <= PH_EXEC;
                PH_EXEC:  phase <= take_irq ? PH_INTR : PH_FETCH;
                default:  phase <= PH_FETCH;
            endcase
        end else begin
            slot <= slot + 1'b1;
        end
    end

    // Interrupt enable: cleared on entry to the interrupt cycle, set by the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)          irq_on <= 1'b1;
        else if (take_irq)   irq_on <= 1'b0;
        else if (irq_enable) irq_on <= 1'b1;
    end

endmodule

// File: rtl/icc_decoder.sv
// Decoder: maps cycle, slot and opcode to the micro-operations of that slot.
// Assumes mbr_zero reflects the buffer register after its increment slot.
// Unknown opcodes end execute after one empty slot.
module icc_decoder
    import icc_pkg::*;
(
    input  phase_e            phase,
    input  logic [SLOT_W-1:0] slot,
    input  logic [OPC_W-1:0]  opcode,
    input  logic              mbr_zero,
    output uop_t              uop
);

    // Slot table for every cycle and instruction.
    always_comb begin
        uop = '0;
        unique case (phase)
            PH_FETCH: begin
                case (slot)
                    2'd0: uop.mar_from_pc = 1'b1;
                    2'd1: begin
                        uop.mbr_from_mem = 1'b1;
                        uop.pc_plus1     = 1'b1;
                    end
                    default: begin
                        uop.ir_load   = 1'b1;
                        uop.last_slot = 1'b1;
                    end
                endcase
            end
            PH_INDIR: begin
                case (slot)
                    2'd0: uop.mar_from_ir  = 1'b1;
                    2'd1: uop.mbr_from_mem = 1'b1;
                    default: begin
                        uop.ir_addr_load = 1'b1;
                        uop.last_slot    = 1'b1;
                    end
                endcase
            end
            PH_INTR: begin
                case (slot)
                    2'd0: uop.mbr_from_pc = 1'b1;
                    2'd1: begin
                        uop.mar_from_save = 1'b1;
                        uop.pc_from_vec   = 1'b1;
                    end
                    default: begin
                        uop.mem_write = 1'b1;
                        uop.last_slot = 1'b1;
                    end
                endcase
            end
            default: begin
                case (opcode)
                    OP_ADD: begin
                        case (slot)
                            2'd0: uop.mar_from_ir  = 1'b1;
                            2'd1: uop.mbr_from_mem = 1'b1;
                            default: begin
                                uop.r1_add    = 1'b1;
                                uop.last_slot = 1'b1;
                            end
                        endcase
                    end
                    OP_ISZ: begin
                        case (slot)
                            2'd0: uop.mar_from_ir  = 1'b1;
                            2'd1: uop.mbr_from_mem = 1'b1;
                            2'd2: uop.mbr_plus1    = 1'b1;
                            default: begin
                                uop.mem_write = 1'b1;
                                uop.pc_plus1  = mbr_zero;
                                uop.last_slot = 1'b1;
                            end
                        endcase
                    end
                    OP_BSA: begin
                        case (slot)
                            2'd0: begin
                                uop.mar_from_ir = 1'b1;
                                uop.mbr_from_pc = 1'b1;
                            end
                            2'd1: begin
                                uop.pc_from_ir = 1'b1;
                                uop.mem_write  = 1'b1;
                            end
                            default: begin
                                uop.pc_plus1  = 1'b1;
                                uop.last_slot = 1'b1;
                            end
                        endcase
                    end
                    default: uop.last_slot = 1'b1;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/icc_datapath.sv
// Datapath: program counter, address, buffer, instruction and R1 registers.
// Assumes memory read data is valid the clock after the address register loads.
// Each register takes at most one source per slot, as the decoder guarantees.
module icc_datapath
    import icc_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int SAVE_ADDR = 0,
    parameter int VEC_ADDR  = 1,
    localparam int WORD_W   = OPC_W + 1 + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  uop_t              uop,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [OPC_W-1:0]  opcode,
    output logic              ind_bit,
    output logic              mbr_zero,
    output logic [ADDR_W-1:0] pc,
    output logic [WORD_W-1:0] r1,
    output logic [WORD_W-1:0] ir
);

    localparam int IND_POS = ADDR_W;
    localparam logic [ADDR_W-1:0] SAVE_A = ADDR_W'(SAVE_ADDR);
    localparam logic [ADDR_W-1:0] VEC_A  = ADDR_W'(VEC_ADDR);

    logic [ADDR_W-1:0] mar;
    logic [WORD_W-1:0] mbr;

    // Program counter: vector load, branch load or increment.
    always_ff @(posedge clk) begin
        if (!rst_n)               pc <= '0;
        else if (uop.pc_from_vec) pc <= VEC_A;
        else if (uop.pc_from_ir)  pc <= ir[ADDR_W-1:0];
        else if (uop.pc_plus1)    pc <= pc + 1'b1;
    end

    // Memory address register sources.
    always_ff @(posedge clk) begin
        if (!rst_n)                 mar <= '0;
        else if (uop.mar_from_pc)   mar <= pc;
        else if (uop.mar_from_ir)   mar <= ir[ADDR_W-1:0];
        else if (uop.mar_from_save) mar <= SAVE_A;
    end

    // Memory buffer register sources.
    always_ff @(posedge clk) begin
        if (!rst_n)               mbr <= '0;
        else if (uop.mbr_from_mem) mbr <= mem_rdata;
        else if (uop.mbr_from_pc)  mbr <= {{(WORD_W-ADDR_W){1'b0}}, pc};
        else if (uop.mbr_plus1)    mbr <= mbr + 1'b1;
    end

    // Instruction register: whole-word load or address-field replacement.
    always_ff @(posedge clk) begin
        if (!rst_n)                ir <= '0;
        else if (uop.ir_load)      ir <= mbr;
        else if (uop.ir_addr_load) ir[ADDR_W-1:0] <= mbr[ADDR_W-1:0];
    end

    // Accumulator update for the add instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)          r1 <= '0;
        else if (uop.r1_add) r1 <= r1 + mbr;
    end

    // Memory port and status back to the controller.
    always_comb begin
        mem_addr  = mar;
        mem_wdata = mbr;
        mem_we    = uop.mem_write;
        opcode    = ir[WORD_W-1 -: OPC_W];
        ind_bit   = mbr[IND_POS];
        mbr_zero  = (mbr == '0);
    end

endmodule

// File: rtl/instr_cycle_ctrl.sv
// Top: hardwired instruction-cycle controller with its register datapath.
// Assumes an external word memory with read data valid one clock after the
// address register loads; writes commit on the clock edge with mem_we high.
module instr_cycle_ctrl
    import icc_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int SAVE_ADDR = 0,
    parameter int VEC_ADDR  = 1,
    localparam int WORD_W   = OPC_W + 1 + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic              irq_enable,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] pc_o,
    output logic [WORD_W-1:0] r1_o,
    output logic [WORD_W-1:0] ir_o,
    output logic [1:0]        phase_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              irq_on_o
);

    phase_e            phase;
    logic [SLOT_W-1:0] slot;
    logic              irq_on;
    uop_t              uop;
    logic [OPC_W-1:0]  opcode;
    logic              ind_bit;
    logic              mbr_zero;

    icc_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .last_slot  (uop.last_slot),
        .ind_bit    (ind_bit),
        .irq_req    (irq_req),
        .irq_enable (irq_enable),
        .phase      (phase),
        .slot       (slot),
        .irq_on     (irq_on)
    );

    icc_decoder u_dec (
        .phase    (phase),
        .slot     (slot),
        .opcode   (opcode),
        .mbr_zero (mbr_zero),
        .uop      (uop)
    );

    icc_datapath #(
        .ADDR_W    (ADDR_W),
        .SAVE_ADDR (SAVE_ADDR),
        .VEC_ADDR  (VEC_ADDR)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .uop       (uop),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .opcode    (opcode),
        .ind_bit   (ind_bit),
        .mbr_zero  (mbr_zero),
        .pc        (pc_o),
        .r1        (r1_o),
        .ir        (ir_o)
    );

    // Observation outputs.
    always_comb begin
        phase_o  = phase;
        slot_o   = slot;
        irq_on_o = irq_on;
    end

endmodule

// File: rtl/icc_checker.sv
// Checker: slot-level timing properties of the controller, bound to the top.
module icc_checker #(
    parameter int ADDR_W   = 11,
    parameter int VEC_ADDR = 1,
    parameter int WORD_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        phase_o,
    input logic [1:0]        slot_o,
    input logic              mem_we,
    input logic [ADDR_W-1:0] pc_o,
    input logic [WORD_W-1:0] r1_o,
    input logic [WORD_W-1:0] ir_o,
    input logic              irq_on_o
);

    // Fetch has three slots and the PC advances right after the second.
    p_fetch_slots_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd0) |-> (slot_o <= 2'd2));

    p_fetch_pc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd0 && slot_o == 2'd1) |=> (pc_o == ADDR_W'($past(pc_o) + 1'b1)));

    // R1 changes only after the final add slot.
    p_r1_exec_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r1_o) |-> ($past(phase_o) == 2'd2 && $past(slot_o) == 2'd2));

    // Interrupt cycle lands on the routine address.
    p_int_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd3 && slot_o == 2'd1) |=> (pc_o == ADDR_W'(VEC_ADDR)));

    // Interrupts are off when the interrupt cycle begins.
    p_int_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd3 && slot_o == 2'd0) |-> !irq_on_o);

    // Instruction register holds through execute.
    p_ir_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd2 && $past(phase_o) == 2'd2) |-> $stable(ir_o));

    // Writes occur only in execute or interrupt cycles.
    p_write_cycles_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (phase_o == 2'd2 || phase_o == 2'd3));

endmodule

bind instr_cycle_ctrl icc_checker #(
    .ADDR_W   (ADDR_W),
    .VEC_ADDR (VEC_ADDR),
    .WORD_W   (WORD_W)
) u_icc_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase_o  (phase_o),
    .slot_o   (slot_o),
    .mem_we   (mem_we),
    .pc_o     (pc_o),
    .r1_o     (r1_o),
    .ir_o     (ir_o),
    .irq_on_o (irq_on_o)
);

// File: tb/instr_cycle_ctrl_test.sv
`timescale 1ns/1ps
module instr_cycle_ctrl_test;

    localparam int AW = 11;
    localparam int WW = 16;
    localparam int MSZ = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          irq_req = 1'b0;
    logic          irq_enable = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [WW-1:0] mem_rdata;
    logic          mem_we;
    logic [WW-1:0] mem_wdata;
    logic [AW-1:0] pc_o;
    logic [WW-1:0] r1_o;
    logic [WW-1:0] ir_o;
    logic [1:0]    phase_o;
    logic [1:0]    slot_o;
    logic          irq_on_o;

    logic [WW-1:0] mem [0:MSZ-1];
    logic [WW-1:0] mm  [0:MSZ-1];
    logic [AW-1:0] mpc;
    logic [WW-1:0] mr1;
    logic          men;
    logic [WW-1:0] mir;
    int            exp_cyc;
    logic [AW-1:0] wa;
    bit            wa_valid;
    bit            int_taken;
    string         op_tag;
    int            n_chk = 0;
    int            n_err = 0;

    always #4 clk = ~clk;

    instr_cycle_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_enable(irq_enable),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .pc_o(pc_o), .r1_o(r1_o), .ir_o(ir_o),
        .phase_o(phase_o), .slot_o(slot_o), .irq_on_o(irq_on_o)
    );

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // Instruction-level model of one fetch-to-fetch step.
    task automatic model_step(input bit irq, input bit pulse);
        logic [WW-1:0] w, v;
        logic [3:0]    op;
        logic [AW-1:0] a;
        if (pulse) men = 1'b1;
        w = mm[mpc];
        mpc = mpc + 1'b1;
        op = w[15:12];
        a = w[AW-1:0];
        exp_cyc = 3;
        wa_valid = 1'b0;
        int_taken = 1'b0;
        if (w[11]) begin
            a = mm[a][AW-1:0];
            exp_cyc += 3;
        end
        mir = {w[15:11], a};
        case (op)
            4'd1: begin mr1 = mr1 + mm[a]; exp_cyc += 3; op_tag = "R3"; end
            4'd2: begin
                v = mm[a] + 1'b1;
                mm[a] = v;
                if (v == '0) mpc = mpc + 1'b1;
                exp_cyc += 4; wa = a; wa_valid = 1'b1; op_tag = "R4";
            end
            4'd3: begin
                mm[a] = {5'd0, mpc};
                mpc = a + 1'b1;
                exp_cyc += 3; wa = a; wa_valid = 1'b1; op_tag = "R5";
            end
            default: begin exp_cyc += 1; op_tag = "R8"; end
        endcase
        if (irq && men) begin
            mm[0] = {5'd0, mpc};
            mpc = 11'd1;
            men = 1'b0;
            exp_cyc += 3;
            int_taken = 1'b1;
        end
    endtask

    // Run one instruction from a fetch boundary to the next and compare.
    task automatic step(input bit irq, input bit pulse);
        int n;
        string ctag;
        irq_req = irq;
        irq_enable = pulse;
        model_step(irq, pulse);
        n = 0;
        do begin
            @(negedge clk);
            irq_enable = 1'b0;
            n++;
        end while (!(phase_o == 2'd0 && slot_o == 2'd0) && n < 64);
        ctag = int_taken ? "R6" : (mir[11] ? "R2" : (op_tag == "R8" ? "R1" : op_tag));
        chk(n == exp_cyc, ctag, "cycle count", n, exp_cyc);
        chk(pc_o == mpc, int_taken ? "R6" : op_tag, "pc", pc_o, mpc);
        chk(r1_o == mr1, op_tag == "R3" ? "R3" : "R8", "r1", r1_o, mr1);
        chk(ir_o == mir, mir[11] ? "R2" : "R10", "ir", ir_o, mir);
        chk(irq_on_o == men, "R7", "irq enable", irq_on_o, men);
        if (wa_valid)
            chk(mem[wa] == mm[wa], op_tag, "written word", mem[wa], mm[wa]);
        if (int_taken)
            chk(mem[0] == mm[0], "R6", "saved pc", mem[0], mm[0]);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        irq_req = 1'b0;
        irq_enable = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mpc = '0; mr1 = '0; men = 1'b1;
        chk(pc_o == '0, "R9", "reset pc", pc_o, 0);
        chk(r1_o == '0, "R9", "reset r1", r1_o, 0);
        chk(phase_o == 2'd0 && slot_o == 2'd0, "R9", "reset phase/slot", {phase_o, slot_o}, 0);
        chk(irq_on_o == 1'b1, "R9", "reset irq enable", irq_on_o, 1);
        chk(mem_we == 1'b0, "R9", "reset write strobe", mem_we, 0);
    endtask

    function automatic logic [WW-1:0] rand_word();
        int r;
        logic [3:0] op;
        r = $urandom % 8;
        if (r == 0) return 16'hFFFF;
        if (r == 1) return WW'($urandom);
        case ($urandom % 5)
            0: op = 4'd0;
            1: op = 4'd1;
            2: op = 4'd2;
            3: op = 4'd3;
            default: op = 4'hF;
        endcase
        return {op, ($urandom % 4) == 0, AW'($urandom)};
    endfunction

    initial begin
        bit irqs [0:10];
        bit pls  [0:10];
        int mism;
        void'($urandom(32'd2718));
        irqs = '{0,0,0,0,0,0,1,1,0,1,0};
        pls  = '{0,0,0,0,0,0,0,0,1,0,0};

        // Directed program: add, indirect add, skip, no skip, branch, no-op, interrupts.
        for (int i = 0; i < MSZ; i++) mem[i] = '0;
        mem[0] = 16'h1100; mem[1] = 16'h1901; mem[2] = 16'h2103; mem[3] = 16'h1100;
        mem[4] = 16'h2104; mem[5] = 16'h3200; mem[11'h201] = 16'hF000; mem[11'h202] = 16'h1100;
        mem[11'h100] = 16'd5; mem[11'h101] = 16'h0102; mem[11'h102] = 16'd7;
        mem[11'h103] = 16'hFFFF; mem[11'h104] = 16'd3;
        for (int i = 0; i < MSZ; i++) mm[i] = mem[i];
        do_reset();
        for (int i = 0; i < 11; i++) step(irqs[i], pls[i]);

        // Random programs with random request and enable pulses.
        for (int i = 0; i < MSZ; i++) begin
            mem[i] = rand_word();
            mm[i] = mem[i];
        end
        do_reset();
        for (int i = 0; i < 3000; i++)
            step(($urandom % 6) == 0, ($urandom % 4) == 0);

        // R11: no stray writes anywhere in memory.
        mism = 0;
        for (int i = 0; i < MSZ; i++) if (mem[i] !== mm[i]) mism++;
        chk(mism == 0, "R11", "memory image mismatches", mism, 0);
        finish_run();
    end

    initial begin
        #(8 * 200000);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end

endmodule